// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the register front end of one bus-master storage DMA channel. Host software reaches three registers through a byte-lane register port: a command register, a status register and a pointer to the descriptor table in memory. The block turns command writes into one-cycle start and stop requests for a separate descriptor walker. It keeps a current table pointer that the walker advances. It tracks whether the channel is active, and it latches the drive's interrupt into a status flag while passing that interrupt straight through to the host.

A start is acted on only when the start bit changes value. Starting always reloads the current pointer from the base pointer. Stopping never aborts an in-flight transfer. The block raises a stop pulse and keeps the channel active until the walker acknowledges that it is idle. The walker datapath, the drive protocol and request draining sit outside this block.

Top module: `bm_dma_ctrl_regs`

## Requirements
- R1: A command write whose start bit (bit 0) equals the stored start bit produces no start pulse, no stop pulse, no pointer reload and no change to the active flag.
- R2: A command write stores only bit 0 (start) and bit 3 (direction). Every other command bit reads back as zero, and the direction bit is stored on every command write.
- R3: A command write that changes start from 0 to 1 reloads the current pointer from the base pointer. If the channel is inactive, it also sets the active flag and raises `walk_start` for one cycle, in the cycle after the write.
- R4: A command write that changes start from 1 to 0 on an active channel raises `walk_stop` for one cycle. The active flag stays set until `walk_idle` is seen. On an inactive channel, such a write raises no stop pulse.
- R5: `host_irq` follows `dev_irq` in the same cycle. A rising `dev_irq` sets the interrupt flag, and a falling `dev_irq` leaves the flag unchanged.
- R6: A pointer write of 1, 2 or 4 bytes (`reg_size` 0, 1, 2) at byte offset `reg_off` replaces only the addressed byte lanes of the base pointer. Bits 1:0 of the pointer always read as zero. Writes with `reg_sel` = 3 change nothing.
- R7: A read returns the selected register shifted down by 8×`reg_off` bits, with lanes above the access size masked to zero. `reg_sel` = 0 selects command, 1 selects status, 2 selects the table pointer, and 3 reads as zero.
- R8: Reset clears the command, status, base pointer, current pointer and run state, and it drops both walker pulses.
- R9: In the status register, bit 0 is active, bit 1 is error and bit 2 is interrupt. Writing 1 to bit 1 or bit 2 clears that flag. Writing 1 to bit 0 has no effect. A `walk_err` pulse sets the error flag.
- R10: `walk_done` with `walk_more` low clears the active flag. `walk_done` with `walk_more` high leaves it set.
- R11: Each `walk_adv` pulse advances the current pointer by DESC_BYTES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| reg_off | input | OFF_W | Byte offset of the access |
| reg_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| reg_wdata | input | PTR_W | Write data, aligned to lane 0 |
| reg_rdata | output | PTR_W | Read data, shifted down by the offset |
| walk_start | output | 1 | One-cycle request to start the descriptor walker |
| walk_stop | output | 1 | One-cycle request to stop the walker |
| walk_idle | input | 1 | Walker acknowledges that it is idle after a stop |
| walk_done | input | 1 | Walker finished a transfer |
| walk_more | input | 1 | Qualifies `walk_done`: more work is pending |
| walk_adv | input | 1 | Walker consumed one descriptor |
| walk_err | input | 1 | Walker reports an error |
| cur_ptr | output | PTR_W | Current descriptor table pointer |
| dma_dir | output | 1 | Stored direction bit |
| dev_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level passed to the host |

## Verification
The bench builds the block with its defaults: a 32-bit pointer (four byte lanes, two offset bits) and an 8-byte descriptor step. With four lanes, every offset from 0 to 3 is reachable, as are all three access sizes, so partial writes that straddle lanes and reads that shift across lanes are exercised. It also drives each run-state path: start from idle, repeated start, stop while active, stop while idle, and done with and without more work.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_BUSY  = 2'd1,
        RUN_DRAIN = 2'd2
    } run_state_e;

    typedef struct packed {
        logic dir;
        logic run;
    } cmd_t;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;
    localparam int ST_ACT_BIT  = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_IRQ_BIT  = 2;

    // number of byte lanes touched by an access of the given size code
    function automatic int lanes_of(input logic [1:0] size);
        case (size)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/bmdma_cmd_ctrl.sv
module bmdma_cmd_ctrl
    import bmdma_regs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic wr_run,
    input  logic wr_dir,
    input  logic walk_done,
    input  logic walk_more,
    input  logic walk_idle,
    output cmd_t cmd_q,
    output logic active,
    output logic reload_cur,
    output logic walk_start,
    output logic walk_stop
);

    run_state_e state_q;
    logic       run_change;

    assign run_change = cmd_wr && (wr_run != cmd_q.run);
    assign reload_cur = run_change && wr_run;
    assign active     = (state_q != RUN_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            state_q    <= RUN_IDLE;
            walk_start <= 1'b0;
            walk_stop  <= 1'b0;
        end else begin
            walk_start <= 1'b0;
            walk_stop  <= 1'b0;
            if (cmd_wr) begin
                cmd_q.run <= wr_run;
                cmd_q.dir <= wr_dir;
            end
            case (state_q)
                RUN_IDLE: begin
                    if (reload_cur) begin
                        state_q    <= RUN_BUSY;
                        walk_start <= 1'b1;
                    end
                end
                RUN_BUSY: begin
                    if (run_change && !wr_run) begin
                        state_q   <= RUN_DRAIN;
                        walk_stop <= 1'b1;
                    end else if (walk_done && !walk_more) begin
                        state_q <= RUN_IDLE;
                    end
                end
                RUN_DRAIN: begin
                    if (walk_idle || (walk_done && !walk_more)) begin
                        state_q <= RUN_IDLE;
                    end
                end
                default: state_q <= RUN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bmdma_status.sv
module bmdma_status (
    input  logic clk,
    input  logic rst,
    input  logic stat_wr,
    input  logic clr_err,
    input  logic clr_irq,
    input  logic walk_err,
    input  logic dev_irq,
    output logic err_q,
    output logic irq_q
);

    logic dev_irq_q;
    logic irq_rise;

    assign irq_rise = dev_irq && !dev_irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_irq_q <= 1'b0;
            err_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            dev_irq_q <= dev_irq;
            // a new event wins over a clear in the same cycle
            if (irq_rise) begin
                irq_q <= 1'b1;
            end else if (stat_wr && clr_irq) begin
                irq_q <= 1'b0;
            end
            if (walk_err) begin
                err_q <= 1'b1;
            end else if (stat_wr && clr_err) begin
                err_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bmdma_ptr_regs.sv
module bmdma_ptr_regs
    import bmdma_regs_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 8,
    localparam int NLANES    = PTR_W / 8,
    localparam int OFF_W     = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_wr,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [PTR_W-1:0] wdata,
    input  logic             reload_cur,
    input  logic             walk_adv,
    output logic [PTR_W-1:0] base_q,
    output logic [PTR_W-1:0] cur_q
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

    logic [PTR_W-1:0] wshift;
    logic [PTR_W-1:0] base_nxt;
    int               nlanes;

    assign wshift = wdata << {off, 3'b000};
    assign nlanes = lanes_of(size);

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic hit;
        assign hit = ptr_wr && (i >= int'(off)) && (i < int'(off) + nlanes);
        if (i == 0) begin : g_low
            // the two lowest pointer bits never hold a one
            assign base_nxt[7:0] = hit ? {wshift[7:2], 2'b00} : base_q[7:0];
        end else begin : g_high
            assign base_nxt[i*8 +: 8] = hit ? wshift[i*8 +: 8] : base_q[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            base_q <= base_nxt;
            if (reload_cur) begin
                cur_q <= base_q;
            end else if (walk_adv) begin
                cur_q <= cur_q + STEP;
            end
        end
    end

endmodule

// File: rtl/bm_dma_ctrl_regs.sv
module bm_dma_ctrl_regs
    import bmdma_regs_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 8,
    localparam int NLANES    = PTR_W / 8,
    localparam int OFF_W     = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [1:0]       reg_size,
    input  logic [PTR_W-1:0] reg_wdata,
    output logic [PTR_W-1:0] reg_rdata,
    output logic             walk_start,
    output logic             walk_stop,
    input  logic             walk_idle,
    input  logic             walk_done,
    input  logic             walk_more,
    input  logic             walk_adv,
    input  logic             walk_err,
    output logic [PTR_W-1:0] cur_ptr,
    output logic             dma_dir,
    input  logic             dev_irq,
    output logic             host_irq
);

    reg_sel_e         sel;
    cmd_t             cmd_q;
    logic             active;
    logic             reload_cur;
    logic             err_q;
    logic             irq_q;
    logic [7:0]       stat_q;
    logic [7:0]       cmd_view;
    logic [PTR_W-1:0] base_q;
    logic [PTR_W-1:0] reg_val;
    logic [PTR_W-1:0] rd_mask;
    int               rd_lanes;

    assign sel = reg_sel_e'(reg_sel);

    bmdma_cmd_ctrl u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (reg_wr && sel == SEL_CMD),
        .wr_run     (reg_wdata[CMD_RUN_BIT]),
        .wr_dir     (reg_wdata[CMD_DIR_BIT]),
        .walk_done  (walk_done),
        .walk_more  (walk_more),
        .walk_idle  (walk_idle),
        .cmd_q      (cmd_q),
        .active     (active),
        .reload_cur (reload_cur),
        .walk_start (walk_start),
        .walk_stop  (walk_stop)
    );

    bmdma_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .stat_wr  (reg_wr && sel == SEL_STAT),
        .clr_err  (reg_wdata[ST_ERR_BIT]),
        .clr_irq  (reg_wdata[ST_IRQ_BIT]),
        .walk_err (walk_err),
        .dev_irq  (dev_irq),
        .err_q    (err_q),
        .irq_q    (irq_q)
    );

    bmdma_ptr_regs #(
        .PTR_W      (PTR_W),
        .DESC_BYTES (DESC_BYTES)
    ) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .ptr_wr     (reg_wr && sel == SEL_PTR),
        .off        (reg_off),
        .size       (reg_size),
        .wdata      (reg_wdata),
        .reload_cur (reload_cur),
        .walk_adv   (walk_adv),
        .base_q     (base_q),
        .cur_q      (cur_ptr)
    );

    always_comb begin
        stat_q              = '0;
        stat_q[ST_ACT_BIT]  = active;
        stat_q[ST_ERR_BIT]  = err_q;
        stat_q[ST_IRQ_BIT]  = irq_q;
        cmd_view              = '0;
        cmd_view[CMD_RUN_BIT] = cmd_q.run;
        cmd_view[CMD_DIR_BIT] = cmd_q.dir;
    end

    always_comb begin
        case (sel)
            SEL_CMD:  reg_val = PTR_W'(cmd_view);
            SEL_STAT: reg_val = PTR_W'(stat_q);
            SEL_PTR:  reg_val = base_q;
            default:  reg_val = '0;
        endcase
    end

    assign rd_lanes = lanes_of(reg_size);

    always_comb begin
        rd_mask = '0;
        for (int k = 0; k < NLANES; k++) begin
            if (k < rd_lanes) rd_mask[k*8 +: 8] = 8'hFF;
        end
    end

    assign reg_rdata = (reg_val >> {reg_off, 3'b000}) & rd_mask;
    assign dma_dir   = cmd_q.dir;
    assign host_irq  = dev_irq;

endmodule

// File: rtl/bm_dma_ctrl_chk.sv
module bm_dma_ctrl_chk
    import bmdma_regs_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_sel,
    input logic [PTR_W-1:0] reg_wdata,
    input logic             walk_start,
    input logic             walk_stop,
    input logic             dev_irq,
    input logic [7:0]       stat_q,
    input logic [7:0]       cmd_view,
    input logic [PTR_W-1:0] cur_ptr
);

    // R1
    same_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd0 && reg_wdata[0] == cmd_view[0])
        |=> (!walk_start && !walk_stop));

    // R3
    start_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        walk_start |-> $past(reg_wr && reg_sel == 2'd0 && reg_wdata[0] && !cmd_view[0]));

    // R3
    start_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        walk_start |-> stat_q[0]);

    // R4
    stop_while_active_chk: assert property (@(posedge clk) disable iff (rst)
        walk_stop |-> stat_q[0]);

    // R4
    start_stop_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(walk_start && walk_stop));

    // R5
    irq_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |=> stat_q[2]);

    // R6
    ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
        cur_ptr[1:0] == 2'b00);

endmodule

bind bm_dma_ctrl_regs bm_dma_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .walk_start (walk_start),
    .walk_stop  (walk_stop),
    .dev_irq    (dev_irq),
    .stat_q     (stat_q),
    .cmd_view   (cmd_view),
    .cur_ptr    (cur_ptr)
);

// File: tb/sim_bm_dma_ctrl_regs.sv
`timescale 1ns/1ps
module sim_bm_dma_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [1:0]  reg_off = 2'd0;
    logic [1:0]  reg_size = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        walk_start, walk_stop;
    logic        walk_idle = 1'b0, walk_done = 1'b0, walk_more = 1'b0;
    logic        walk_adv = 1'b0, walk_err = 1'b0;
    logic [31:0] cur_ptr;
    logic        dma_dir;
    logic        dev_irq = 1'b0;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bm_dma_ctrl_regs u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .walk_start(walk_start), .walk_stop(walk_stop),
        .walk_idle(walk_idle), .walk_done(walk_done), .walk_more(walk_more),
        .walk_adv(walk_adv), .walk_err(walk_err), .cur_ptr(cur_ptr),
        .dma_dir(dma_dir), .dev_irq(dev_irq), .host_irq(host_irq)
    );

    typedef struct packed {
        logic [1:0]  woff;
        logic [1:0]  wsz;
        logic [31:0] wd;
        logic [1:0]  roff;
        logic [1:0]  rsz;
        logic [31:0] exp;
    } vec_t;

    // R6 partial writes into the pointer, R7 shifted partial reads back
    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd2, 32'h1234_5677, 2'd0, 2'd2, 32'h1234_5674},
        '{2'd1, 2'd0, 32'h0000_00AB, 2'd1, 2'd0, 32'h0000_00AB},
        '{2'd2, 2'd1, 32'h0000_BEEF, 2'd2, 2'd1, 32'h0000_BEEF},
        '{2'd0, 2'd0, 32'h0000_00FF, 2'd0, 2'd0, 32'h0000_00FC},
        '{2'd3, 2'd0, 32'h0000_0001, 2'd3, 2'd0, 32'h0000_0001},
        '{2'd2, 2'd0, 32'h0000_005A, 2'd1, 2'd1, 32'h0000_5AAB},
        '{2'd0, 2'd1, 32'h0000_1233, 2'd0, 2'd2, 32'h015A_1230},
        '{2'd0, 2'd2, 32'hFFFF_FFFF, 2'd2, 2'd0, 32'h0000_00FF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                      input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_off = off; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                      input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_off = off; reg_size = sz;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_adv();
        @(negedge clk); walk_adv = 1'b1;
        @(negedge clk); walk_adv = 1'b0;
    endtask

    task automatic pulse_done(input logic more);
        @(negedge clk); walk_done = 1'b1; walk_more = more;
        @(negedge clk); walk_done = 1'b0; walk_more = 1'b0;
    endtask

    task automatic pulse_idle();
        @(negedge clk); walk_idle = 1'b1;
        @(negedge clk); walk_idle = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); walk_err = 1'b1;
        @(negedge clk); walk_err = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        rd(2'd0, 2'd0, 2'd2, d); check("R8 cmd after reset", d, 32'h0);
        rd(2'd1, 2'd0, 2'd2, d); check("R8 status after reset", d, 32'h0);
        rd(2'd2, 2'd0, 2'd2, d); check("R8 pointer after reset", d, 32'h0);
        check("R8 cur_ptr after reset", cur_ptr, 32'h0);

        for (int i = 0; i < 8; i++) begin
            wr(2'd2, VECS[i].woff, VECS[i].wsz, VECS[i].wd);
            rd(2'd2, VECS[i].roff, VECS[i].rsz, d);
            check($sformatf("R6 R7 vector %0d", i), d, VECS[i].exp);
        end

        wr(2'd2, 2'd0, 2'd2, 32'h0000_1003);
        rd(2'd2, 2'd0, 2'd2, d); check("R6 low bits forced", d, 32'h0000_1000);

        // R6 select 3 ignored, R7 reads zero
        wr(2'd3, 2'd0, 2'd2, 32'hDEAD_BEEF);
        rd(2'd2, 2'd0, 2'd2, d); check("R6 sel3 write ignored", d, 32'h0000_1000);
        rd(2'd3, 2'd0, 2'd2, d); check("R7 sel3 reads zero", d, 32'h0);

        // R3 start from idle
        wr(2'd0, 2'd0, 2'd0, 32'h0000_00FF);
        check("R3 walk_start pulse", {31'd0, walk_start}, 32'd1);
        check("R3 cur reloaded", cur_ptr, 32'h0000_1000);
        rd(2'd0, 2'd0, 2'd2, d); check("R2 cmd keeps bits 0 and 3", d, 32'h09);
        check("R2 dma_dir", {31'd0, dma_dir}, 32'd1);
        rd(2'd1, 2'd0, 2'd2, d); check("R3 active set", d, 32'h01);
        check("R3 start pulse one cycle", {31'd0, walk_start}, 32'd0);

        // R11 advance
        pulse_adv(); pulse_adv();
        #1 check("R11 cur advanced", cur_ptr, 32'h0000_1010);

        // R1 rewrite same start value
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R1 no start on rewrite", {31'd0, walk_start}, 32'd0);
        check("R1 no reload on rewrite", cur_ptr, 32'h0000_1010);
        rd(2'd0, 2'd0, 2'd2, d); check("R2 dir cleared by rewrite", d, 32'h01);

        // R10 done with and without more
        pulse_done(1'b1);
        rd(2'd1, 2'd0, 2'd2, d); check("R10 more keeps active", d, 32'h01);
        pulse_done(1'b0);
        rd(2'd1, 2'd0, 2'd2, d); check("R10 done clears active", d, 32'h00);

        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R1 same start after done", {31'd0, walk_start}, 32'd0);
        rd(2'd1, 2'd0, 2'd2, d); check("R1 active unchanged", d, 32'h00);

        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        check("R4 no stop when idle", {31'd0, walk_stop}, 32'd0);

        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R3 restart pulse", {31'd0, walk_start}, 32'd1);
        check("R3 restart reload", cur_ptr, 32'h0000_1000);

        // R4 stop waits for idle
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        check("R4 stop pulse", {31'd0, walk_stop}, 32'd1);
        repeat (3) @(negedge clk);
        rd(2'd1, 2'd0, 2'd2, d); check("R4 active held while draining", d, 32'h01);
        pulse_idle();
        rd(2'd1, 2'd0, 2'd2, d); check("R4 idle clears active", d, 32'h00);

        // R5 interrupt
        @(negedge clk); dev_irq = 1'b1;
        #1 check("R5 host_irq rises", {31'd0, host_irq}, 32'd1);
        rd(2'd1, 2'd0, 2'd2, d); check("R5 irq latched", d, 32'h04);
        dev_irq = 1'b0;
        #1 check("R5 host_irq falls", {31'd0, host_irq}, 32'd0);
        rd(2'd1, 2'd0, 2'd2, d); check("R5 fall keeps flag", d, 32'h04);

        // R9 status write semantics
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0001);
        rd(2'd1, 2'd0, 2'd2, d); check("R9 bit0 write ignored", d, 32'h04);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd(2'd1, 2'd0, 2'd2, d); check("R9 irq cleared", d, 32'h00);
        pulse_err();
        rd(2'd1, 2'd0, 2'd2, d); check("R9 error set", d, 32'h02);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd(2'd1, 2'd0, 2'd2, d); check("R9 error kept", d, 32'h02);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0002);
        rd(2'd1, 2'd0, 2'd2, d); check("R9 error cleared", d, 32'h00);

        // R8 reset while active
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(2'd0, 2'd0, 2'd2, d); check("R8 cmd cleared", d, 32'h0);
        rd(2'd1, 2'd0, 2'd2, d); check("R8 status cleared", d, 32'h0);
        rd(2'd2, 2'd0, 2'd2, d); check("R8 base cleared", d, 32'h0);
        check("R8 cur cleared", cur_ptr, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule